// File: doc/BRIEF.md
# Fractional PLL Frequency Word Calculator

This block turns a requested output rate and a reference rate into the two words that program a fractional-N synthesizer. The first is an integer multiplier L. The second is a fractional word alpha. The block also reports the rate that those words actually produce. A controller pulses `start` with the two 64-bit rates and a mode bit, then waits for `done` and copies the words into the synthesizer's registers.

Both divisions run on a single iterative restoring divider that yields one quotient bit per clock. The first pass produces L and a remainder. If that remainder is nonzero, a second pass divides it, scaled up by the fraction width, to produce alpha. Alpha is rounded up whenever the second pass leaves a remainder.

There are two modes. In unsigned mode alpha is a 32-bit fraction, placed in the upper bits of a wider register field. In signed mode alpha is a 16-bit two's-complement fraction in [-0.5, 0.5). In that mode, a fraction of one half or more is folded into L+1 together with a negative alpha.

Top module: `fpll_word_calc`

## Requirements
- R1: `l_word` equals the integer quotient of `req_rate` divided by `ref_rate`. When that division is exact, alpha is 0 and `achieved_rate` equals `req_rate`.
- R2: When the remainder is nonzero, alpha is the ceiling of (remainder × 2^W) / `ref_rate`. W is 32 when `signed_mode`=0 and 16 when `signed_mode`=1.
- R3: `achieved_rate` is `ref_rate` × L plus (`ref_rate` × alpha) >> W, taken modulo 2^64. In signed mode, L here is the multiplier before any fold of R4.
- R4: In signed mode, alpha sits in `alpha_field` bits [15:0] and all higher bits are zero. When alpha bit 15 is set, `l_word` is the quotient plus one, and `achieved_rate` treats alpha as a negative fraction.
- R5: If the rounded-up alpha reaches 2^W, it wraps to 0 and `l_word` is incremented instead.
- R6: With `signed_mode`=0, `margin_err` is 1 exactly when `achieved_rate` is below `req_rate` or exceeds it by more than 500. With `signed_mode`=1, `margin_err` is always 0.
- R7: In unsigned mode, the 32-bit alpha occupies the top 32 bits of the 40-bit `alpha_field`, and bits [7:0] are zero.
- R8: A start with `ref_rate`=0 runs no division. `done` rises after one clock with `zero_ref_err`=1 and all words and `margin_err` at 0. The next completed run with a nonzero reference clears `zero_ref_err`.
- R9: `done` is high for exactly one cycle. All outputs stay unchanged from that cycle until the next run completes.
- R10: A `start` pulse while a calculation is in progress is ignored. The result is that of the run already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; samples the rates and mode |
| signed_mode | input | 1 | 0: 32-bit unsigned alpha; 1: 16-bit signed alpha |
| req_rate | input | 64 | Requested output rate |
| ref_rate | input | 64 | Reference rate |
| l_word | output | 64 | Integer multiplier L |
| alpha_field | output | 40 | Fractional word as placed in its register field |
| achieved_rate | output | 64 | Rate produced by `l_word` and alpha |
| margin_err | output | 1 | Achieved rate outside the allowed window (unsigned mode) |
| zero_ref_err | output | 1 | Last run had a zero reference |
| done | output | 1 | One-cycle completion pulse |

## Verification
The inputs are chosen to separate the block's arithmetic paths:
- An exact multiple exercises the path where alpha is skipped.
- A request below the reference gives L=0.
- Fractions of one quarter and three quarters in signed mode tell apart the cases with and without the fold into L+1.
- A remainder of one below the reference, in each mode, drives the rounded-up alpha into the carry.
- A reference near 2^50 makes the rounding error larger than the margin. This separates the unsigned flag from the signed mode, where the flag stays quiet.

Two more sequences are checked: a zero reference followed by a normal run, and a second start pulse issued mid-division.

// File: rtl/fpll_calc_pkg.sv
package fpll_calc_pkg;

  parameter int FPLL_RATE_W  = 64;
  parameter int FPLL_UFRAC_W = 32;
  parameter int FPLL_SFRAC_W = 16;

  typedef logic [FPLL_RATE_W-1:0]  rate_t;
  typedef logic [FPLL_UFRAC_W-1:0] ufrac_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INT,
    ST_FRAC,
    ST_FIN
  } calc_state_e;

  // Rate produced by a multiplier and a fraction. In signed mode the fraction
  // is two's complement, so the multiplier is reduced by one when it is negative.
  function automatic rate_t fpll_eval_rate(input rate_t refr, input rate_t lval,
                                           input ufrac_t alpha, input logic sgn);
    logic [2*FPLL_RATE_W-1:0] prod;
    rate_t                    l_eff;
    l_eff = (sgn && alpha[FPLL_SFRAC_W-1]) ? lval - rate_t'(1) : lval;
    prod  = {{FPLL_RATE_W{1'b0}}, refr} *
            {{(2*FPLL_RATE_W-FPLL_UFRAC_W){1'b0}}, alpha};
    prod  = sgn ? (prod >> FPLL_SFRAC_W) : (prod >> FPLL_UFRAC_W);
    return (refr * l_eff) + prod[FPLL_RATE_W-1:0];
  endfunction

  // Window check on the achieved rate (unsigned mode only).
  function automatic logic fpll_margin_bad(input rate_t ach, input rate_t req,
                                           input logic sgn, input int unsigned margin);
    logic [FPLL_RATE_W:0] upper;
    upper = {1'b0, req} + (FPLL_RATE_W+1)'(margin);
    return !sgn && ((ach < req) || ({1'b0, ach} > upper));
  endfunction

endpackage

// File: rtl/fpll_restoring_div.sv
module fpll_restoring_div #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     divisor,
  input  logic [W-1:0]     init_rem,
  input  logic [W-1:0]     dividend,
  input  logic [CNT_W-1:0] steps,
  output logic             busy,
  output logic             fin,
  output logic [W-1:0]     quot,
  output logic [W-1:0]     rem
);

  logic [W-1:0]     div_q;
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       trial;
  logic [W:0]       sub;
  logic             take;

  // One restoring step: shift in the next dividend bit, subtract if it fits.
  always_comb begin
    trial = {rem, sh_q[W-1]};
    sub   = trial - {1'b0, div_q};
    take  = ~sub[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
      rem   <= '0;
      quot  <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        div_q <= divisor;
        sh_q  <= dividend;
        rem   <= init_rem;
        quot  <= '0;
        cnt_q <= steps;
        busy  <= 1'b1;
      end else if (busy) begin
        rem   <= take ? sub[W-1:0] : trial[W-1:0];
        sh_q  <= sh_q << 1;
        quot  <= {quot[W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R2: partial remainder stays below the divisor throughout a division
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < div_q));

  // R9: the completion pulse is only seen once the divider has gone idle
  a_r9_fin_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);

endmodule

// File: rtl/fpll_rate_eval.sv
module fpll_rate_eval
  import fpll_calc_pkg::*;
#(
  parameter int unsigned MARGIN = 500
) (
  input  rate_t  refr,
  input  rate_t  req,
  input  rate_t  lval,
  input  ufrac_t alpha,
  input  logic   sgn,
  output rate_t  ach,
  output logic   margin_bad
);

  always_comb begin
    ach        = fpll_eval_rate(refr, lval, alpha, sgn);
    margin_bad = fpll_margin_bad(ach, req, sgn, MARGIN);
  end

endmodule

// File: rtl/fpll_word_calc.sv
module fpll_word_calc
  import fpll_calc_pkg::*;
#(
  parameter int          FIELD_W = 40,
  parameter int unsigned MARGIN  = 500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   signed_mode,
  input  logic [FPLL_RATE_W-1:0] req_rate,
  input  logic [FPLL_RATE_W-1:0] ref_rate,
  output logic [FPLL_RATE_W-1:0] l_word,
  output logic [FIELD_W-1:0]     alpha_field,
  output logic [FPLL_RATE_W-1:0] achieved_rate,
  output logic                   margin_err,
  output logic                   zero_ref_err,
  output logic                   done
);

  localparam int CNT_W = $clog2(FPLL_RATE_W+1);
  localparam int PAD_W = FIELD_W - FPLL_UFRAC_W;

  calc_state_e           state_q;
  rate_t                 req_q, ref_q, lraw_q;
  logic                  sgn_q;
  logic [FPLL_UFRAC_W:0] afull_q;

  // divider hookup
  logic             div_load, div_busy, div_fin;
  rate_t            div_divisor, div_init, div_dvd, div_quot, div_rem;
  logic [CNT_W-1:0] div_steps;

  // finish-stage events, brought out as named wires
  logic         carry_w, fold_w;
  ufrac_t       alpha_w;
  rate_t        l_fin, ach_fin;
  logic         merr_fin;
  logic [FIELD_W-1:0] field_u, field_fin;
  logic         run_accept, zero_accept;

  assign run_accept  = (state_q == ST_IDLE) && start && (ref_rate != '0);
  assign zero_accept = (state_q == ST_IDLE) && start && (ref_rate == '0);

  always_comb begin
    div_load    = 1'b0;
    div_init    = '0;
    div_dvd     = '0;
    div_steps   = '0;
    div_divisor = (state_q == ST_IDLE) ? ref_rate : ref_q;
    if (run_accept) begin
      div_load  = 1'b1;
      div_dvd   = req_rate;
      div_steps = CNT_W'(FPLL_RATE_W);
    end else if ((state_q == ST_INT) && div_fin && (div_rem != '0)) begin
      div_load  = 1'b1;
      div_init  = div_rem;
      div_steps = sgn_q ? CNT_W'(FPLL_SFRAC_W) : CNT_W'(FPLL_UFRAC_W);
    end
  end

  fpll_restoring_div #(.W(FPLL_RATE_W), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .divisor  (div_divisor),
    .init_rem (div_init),
    .dividend (div_dvd),
    .steps    (div_steps),
    .busy     (div_busy),
    .fin      (div_fin),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  // Carry of a rounded-up fraction and the signed fold into L+1.
  always_comb begin
    if (sgn_q) begin
      alpha_w = {{(FPLL_UFRAC_W-FPLL_SFRAC_W){1'b0}}, afull_q[FPLL_SFRAC_W-1:0]};
      carry_w = afull_q[FPLL_SFRAC_W];
    end else begin
      alpha_w = afull_q[FPLL_UFRAC_W-1:0];
      carry_w = afull_q[FPLL_UFRAC_W];
    end
    fold_w = sgn_q && alpha_w[FPLL_SFRAC_W-1];
    l_fin  = lraw_q + {{(FPLL_RATE_W-1){1'b0}}, carry_w}
                    + {{(FPLL_RATE_W-1){1'b0}}, fold_w};
  end

  generate
    if (PAD_W > 0) begin : g_wide_field
      assign field_u = {alpha_w, {PAD_W{1'b0}}};
    end else begin : g_exact_field
      assign field_u = alpha_w;
    end
  endgenerate

  assign field_fin = sgn_q ? FIELD_W'(alpha_w[FPLL_SFRAC_W-1:0]) : field_u;

  fpll_rate_eval #(.MARGIN(MARGIN)) u_eval (
    .refr       (ref_q),
    .req        (req_q),
    .lval       (l_fin),
    .alpha      (alpha_w),
    .sgn        (sgn_q),
    .ach        (ach_fin),
    .margin_bad (merr_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      req_q         <= '0;
      ref_q         <= '0;
      sgn_q         <= 1'b0;
      lraw_q        <= '0;
      afull_q       <= '0;
      l_word        <= '0;
      alpha_field   <= '0;
      achieved_rate <= '0;
      margin_err    <= 1'b0;
      zero_ref_err  <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            req_q <= req_rate;
            ref_q <= ref_rate;
            sgn_q <= signed_mode;
          end
          if (zero_accept) begin
            l_word        <= '0;
            alpha_field   <= '0;
            achieved_rate <= '0;
            margin_err    <= 1'b0;
            zero_ref_err  <= 1'b1;
            done          <= 1'b1;
          end else if (run_accept) begin
            state_q <= ST_INT;
          end
        end
        ST_INT: begin
          if (div_fin) begin
            lraw_q <= div_quot;
            if (div_rem == '0) begin
              afull_q <= '0;
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_FRAC;
            end
          end
        end
        ST_FRAC: begin
          if (div_fin) begin
            afull_q <= {1'b0, div_quot[FPLL_UFRAC_W-1:0]}
                       + {{FPLL_UFRAC_W{1'b0}}, (div_rem != '0)};
            state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          l_word        <= l_fin;
          alpha_field   <= field_fin;
          achieved_rate <= ach_fin;
          margin_err    <= merr_fin;
          zero_ref_err  <= 1'b0;
          done          <= 1'b1;
          state_q       <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a zero reference reports all-zero words
  a_r8_zero_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_ref_err) |-> (l_word == '0 && alpha_field == '0 &&
                                achieved_rate == '0 && !margin_err));

  // R4: signed alpha never reaches above its 16-bit field
  a_r4_signed_field_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sgn_q) |-> (alpha_field[FIELD_W-1:FPLL_SFRAC_W] == '0));

  // R6: signed runs never raise the margin flag
  a_r6_signed_no_margin: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sgn_q) |-> !margin_err);

  // R10: captured operands hold while a calculation runs
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(req_q) && $stable(ref_q) && $stable(sgn_q)));

endmodule

// File: tb/test_fpll_word_calc.sv
`timescale 1ns/1ps
module test_fpll_word_calc;

  localparam int FW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          signed_mode = 1'b0;
  logic [63:0]   req_rate = '0;
  logic [63:0]   ref_rate = '0;
  logic [63:0]   l_word;
  logic [FW-1:0] alpha_field;
  logic [63:0]   achieved_rate;
  logic          margin_err, zero_ref_err, done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fpll_word_calc i_fpll_word_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .req_rate(req_rate), .ref_rate(ref_rate), .l_word(l_word),
    .alpha_field(alpha_field), .achieved_rate(achieved_rate),
    .margin_err(margin_err), .zero_ref_err(zero_ref_err), .done(done)
  );

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected words computed straight from the requirement text.
  task automatic model(input logic [63:0] rq, input logic [63:0] rf, input logic s,
                       output logic [63:0] el, output logic [FW-1:0] ef,
                       output logic [63:0] ea, output logic em);
    logic [127:0] q, r, a, tmp;
    int w;
    w = s ? 16 : 32;
    q = {64'd0, rq} / {64'd0, rf};
    r = {64'd0, rq} % {64'd0, rf};
    if (r == 0) a = 0;
    else a = ((r << w) + {64'd0, rf} - 1) / {64'd0, rf};
    if (a == (128'd1 << w)) begin
      q = q + 1;
      a = 0;
    end
    el  = q[63:0] + ((s && a >= 128'd32768) ? 64'd1 : 64'd0);
    tmp = (q * {64'd0, rf}) + (({64'd0, rf} * a) >> w);
    ea  = tmp[63:0];
    em  = !s && ((ea < rq) || ({1'b0, ea} > ({1'b0, rq} + 65'd500)));
    ef  = s ? {24'd0, a[15:0]} : {a[31:0], 8'd0};
  endtask

  task automatic launch(input logic [63:0] rq, input logic [63:0] rf, input logic s);
    @(negedge clk);
    req_rate = rq; ref_rate = rf; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    for (int i = 0; i < 2000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk(tag, "done timeout", 0, 1);
  endtask

  task automatic check_words(input string tag, input logic [63:0] rq,
                             input logic [63:0] rf, input logic s);
    logic [63:0] el, ea;
    logic [FW-1:0] ef;
    logic em;
    model(rq, rf, s, el, ef, ea, em);
    chk(tag, "l_word", l_word, el);
    chk(tag, "alpha_field", alpha_field, ef);
    chk(tag, "achieved_rate", achieved_rate, ea);
    chk(tag, "margin_err", margin_err, em);
    chk(tag, "zero_ref_err", zero_ref_err, 0);
  endtask

  // One full run followed by the R9 pulse-width and hold check.
  task automatic run_case(input string tag, input logic [63:0] rq,
                          input logic [63:0] rf, input logic s);
    logic [63:0] l_keep;
    launch(rq, rf, s);
    wait_done(tag);
    check_words(tag, rq, rf, s);
    l_keep = l_word;
    @(negedge clk);
    chk("R9", "done after pulse", done, 0);
    repeat (3) @(negedge clk);
    chk("R9", "l_word held", l_word, l_keep);
  endtask

  task automatic t_reset;
    chk("R9", "reset done", done, 0);
    chk("R8", "reset zero_ref_err", zero_ref_err, 0);
    chk("R1", "reset l_word", l_word, 0);
  endtask

  task automatic t_zero_ref;
    launch(64'd1000, 64'd0, 1'b0);
    wait_done("R8");
    chk("R8", "zero_ref_err", zero_ref_err, 1);
    chk("R8", "l_word", l_word, 0);
    chk("R8", "alpha_field", alpha_field, 0);
    chk("R8", "achieved_rate", achieved_rate, 0);
    chk("R8", "margin_err", margin_err, 0);
    run_case("R8", 64'd1_000_000_000, 64'd19_200_000, 1'b0);
  endtask

  task automatic t_start_ignored;
    launch(64'd1_000_000_000, 64'd19_200_000, 1'b0);
    repeat (6) @(negedge clk);
    req_rate = 64'd777_777_777; ref_rate = 64'd3; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    check_words("R10", 64'd1_000_000_000, 64'd19_200_000, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R1", 64'd960_000_000, 64'd19_200_000, 1'b0);              // exact multiple
    run_case("R1", 64'd5, 64'd7, 1'b0);                                  // below reference
    run_case("R2", 64'd1_000_000_000, 64'd19_200_000, 1'b0);            // R3 R7 fraction
    run_case("R3", 64'd772_800_000, 64'd19_200_000, 1'b1);              // signed, quarter
    run_case("R4", 64'd782_400_000, 64'd19_200_000, 1'b1);              // signed, 3/4 folds
    run_case("R5", 64'd787_199_999, 64'd19_200_000, 1'b1);              // signed carry
    run_case("R5", (64'd1 << 42) - 64'd1, 64'd1 << 40, 1'b0);           // unsigned carry
    run_case("R6", (64'd3 << 50) + 64'd1, 64'd1 << 50, 1'b0);           // margin exceeded
    run_case("R6", (64'd3 << 50) + 64'd1, 64'd1 << 50, 1'b1);           // signed: no flag
    run_case("R7", 64'd2_000_000_123, 64'd27_000_000, 1'b0);            // field placement
    t_zero_ref();
    t_start_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule